// File: doc/BRIEF.md
# 16-bit Capture/Compare Timer

A general-purpose timer built around one free-running 16-bit up-counter. The counter advances either on a tick from an 8-bit programmable clock divider or on rising edges of an external event input. A single counter serves three uses at the same time: it can latch its value when an edge arrives on a capture input, it can fire a compare match against a reference value, and it can count external events.

On a compare match the block can drive a dedicated output pin. The pin either drops low for one clock or changes level on each match. The match can optionally restart the counter from zero, which turns the reference value into a period. Capture and compare events set sticky status flags that software clears by writing 1. Each flag has its own interrupt enable, and the interrupt line is the OR of the enabled flags.

Software reaches the block through a flat word-addressed register port with combinational read data. The word addresses are: control 0, divider 1, reference 2, capture 3, count 4, status 5. Control bits are: [0] run, [1] event source, [3:2] capture edge, [4] toggle mode, [5] pin enable, [6] restart on match, [7] capture interrupt enable, [8] compare interrupt enable.

Top module: `cap_cmp_timer`

## Requirements
- R1: After reset, count, capture, status and divider read 0, `cmp_o` is 1 and `irq_o` is 0.
- R2: With run=1, event source=0 and divider value N, the count advances once every N+1 clocks, counted from a count write.
- R3: With run=1 and event source=1, the count advances once per rising edge of `evt_i` seen after a two-flop synchronizer, and clock ticks do not advance it.
- R4: Without restart, the count wraps from 0xFFFF to 0x0000.
- R5: The capture edge field selects which edges of `cap_i` load the count into the capture register and set status bit 0: 0 none, 1 rising, 2 falling, 3 both. The loaded value is the count two clock edges after the edge that samples the input change.
- R6: When the count equals the reference and an advance occurs, status bit 1 is set on that edge and the count moves on to reference+1.
- R7: With restart=1, the advance that matches loads 0 instead of reference+1.
- R8: In pulse mode (toggle=0) with pin enable=1, `cmp_o` is 0 for exactly the one clock after a match edge.
- R9: In toggle mode with pin enable=1, `cmp_o` inverts on each match and otherwise holds. A control write sets it back to 1.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A new event in the same cycle as a clearing write wins.
- R11: `irq_o` is 1 exactly when some status bit and its interrupt enable are both 1.
- R12: A write to the count register loads the count and restarts the divider phase.
- R13: With pin enable=0, `cmp_o` stays 1 through matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i (combinational) |
| cap_i | input | 1 | Asynchronous capture input |
| evt_i | input | 1 | Asynchronous event-count input |
| cmp_o | output | 1 | Compare output pin, idle high |
| irq_o | output | 1 | Interrupt request |

## Verification
A capture edge and a compare match can both land on the same clock edge. The bench provokes this by raising `cap_i` exactly two edges before the count reaches the reference. It then expects both status bits to be set together and the capture register to hold the reference value. A second collision is a status-clear write on the match edge itself, and the compare flag must survive it. The divider is swept over small values and its maximum, and the capture logic over every edge mode with both input polarities.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int A_CTRL  = 0;
  localparam int A_PRESC = 1;
  localparam int A_REF   = 2;
  localparam int A_CAP   = 3;
  localparam int A_CNT   = 4;
  localparam int A_STAT  = 5;

  localparam int B_RUN     = 0;
  localparam int B_EXT     = 1;
  localparam int B_EDGE    = 2;
  localparam int B_TOGGLE  = 4;
  localparam int B_OUT_EN  = 5;
  localparam int B_RESTART = 6;
  localparam int B_CAP_IE  = 7;
  localparam int B_REF_IE  = 8;
  localparam int CTRL_W    = 9;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } cap_edge_e;
endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic chg_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  assign lvl_o = sh_q[STAGES-1];
  assign chg_o = sh_q[STAGES] ^ sh_q[STAGES-1];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic [PW-1:0] div_i,
  output logic          tick_o
);
  logic [PW-1:0] phase_q;

  // >= keeps the period bounded when div_i shrinks mid-count
  assign tick_o = en_i && !clr_i && (phase_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               phase_q <= '0;
    else if (clr_i || !en_i)   phase_q <= '0;
    else if (tick_o)           phase_q <= '0;
    else                       phase_q <= phase_q + 1'b1;
  end

  assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && (div_i != '0) |=> !tick_o || (div_i == '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic [CW-1:0] ref_i,
  input  logic          restart_i,
  output logic [CW-1:0] cnt_o,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;

  assign hit_o = inc_i && !load_i && (cnt_q == ref_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (hit_o && restart_i)   cnt_q <= '0;
    else if (inc_i)                cnt_q <= cnt_q + 1'b1;
  end

  assert_count_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !load_i && !(hit_o && restart_i) |=> cnt_q == $past(cnt_q) + CW'(1));
  assert_restart_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o && restart_i |=> cnt_q == '0);
  assert_count_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !load_i |=> $stable(cnt_q));
  assert_load_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/tmr_out_stage.sv
module tmr_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic toggle_i,
  input  logic reinit_i,
  output logic pin_o
);
  logic pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pin_q <= 1'b1;
    else if (reinit_i) pin_q <= 1'b1;
    else if (toggle_i) pin_q <= pin_q ^ hit_i;
    else               pin_q <= !hit_i;
  end

  assign pin_o = pin_q;

  assert_pulse_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && !toggle_i && !reinit_i |=> !pin_o);
  assert_pulse_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i && !toggle_i |=> pin_o);
  assert_toggle_flip_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && toggle_i && !reinit_i |=> pin_o != $past(pin_o));
  assert_toggle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_i && toggle_i && !reinit_i |=> $stable(pin_o));
endmodule

// File: rtl/cap_cmp_timer.sv
module cap_cmp_timer
  import tmr_pkg::*;
#(
  parameter int CW          = 16,
  parameter int PW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int AW          = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] rdata_o,
  input  logic          cap_i,
  input  logic          evt_i,
  output logic          cmp_o,
  output logic          irq_o
);
  localparam int NSTAT = 2;

  logic [CTRL_W-1:0] ctrl_q;
  logic [PW-1:0]     presc_q;
  logic [CW-1:0]     ref_q, cap_q, cnt;
  logic [NSTAT-1:0]  stat_q, stat_clr;

  logic wr_ctrl, wr_presc, wr_ref, wr_cnt, wr_stat;
  assign wr_ctrl  = we_i && (addr_i == AW'(A_CTRL));
  assign wr_presc = we_i && (addr_i == AW'(A_PRESC));
  assign wr_ref   = we_i && (addr_i == AW'(A_REF));
  assign wr_cnt   = we_i && (addr_i == AW'(A_CNT));
  assign wr_stat  = we_i && (addr_i == AW'(A_STAT));

  logic run, ext_src, toggle, out_en, restart;
  cap_edge_e cap_edge;
  assign run      = ctrl_q[B_RUN];
  assign ext_src  = ctrl_q[B_EXT];
  assign toggle   = ctrl_q[B_TOGGLE];
  assign out_en   = ctrl_q[B_OUT_EN];
  assign restart  = ctrl_q[B_RESTART];
  assign cap_edge = cap_edge_e'(ctrl_q[B_EDGE +: 2]);

  // input conditioning
  logic cap_lvl, cap_chg, evt_lvl, evt_chg;

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk_i, .rst_ni, .d_i(cap_i), .lvl_o(cap_lvl), .chg_o(cap_chg)
  );
  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_evt_sync (
    .clk_i, .rst_ni, .d_i(evt_i), .lvl_o(evt_lvl), .chg_o(evt_chg)
  );

  logic cap_hit;
  always_comb begin
    unique case (cap_edge)
      EDGE_RISE: cap_hit = cap_chg && cap_lvl;
      EDGE_FALL: cap_hit = cap_chg && !cap_lvl;
      EDGE_BOTH: cap_hit = cap_chg;
      default:   cap_hit = 1'b0;
    endcase
  end

  // count source
  logic tick, inc, ref_hit;

  tmr_prescaler #(.PW(PW)) u_presc (
    .clk_i, .rst_ni,
    .en_i  (run && !ext_src),
    .clr_i (wr_cnt),
    .div_i (presc_q),
    .tick_o(tick)
  );

  assign inc = run && (ext_src ? (evt_chg && evt_lvl) : tick);

  tmr_counter #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni,
    .inc_i     (inc),
    .load_i    (wr_cnt),
    .load_val_i(wdata_i),
    .ref_i     (ref_q),
    .restart_i (restart),
    .cnt_o     (cnt),
    .hit_o     (ref_hit)
  );

  logic pin;
  tmr_out_stage u_out (
    .clk_i, .rst_ni,
    .hit_i   (ref_hit),
    .toggle_i(toggle),
    .reinit_i(wr_ctrl),
    .pin_o   (pin)
  );

  assign cmp_o = out_en ? pin : 1'b1;

  // registers
  assign stat_clr = wr_stat ? wdata_i[NSTAT-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      ref_q   <= '0;
      cap_q   <= '0;
      stat_q  <= '0;
    end else begin
      if (wr_ctrl)  ctrl_q  <= wdata_i[CTRL_W-1:0];
      if (wr_presc) presc_q <= wdata_i[PW-1:0];
      if (wr_ref)   ref_q   <= wdata_i;
      if (cap_hit)  cap_q   <= cnt;
      // event set wins over a same-cycle clear
      stat_q <= (stat_q & ~stat_clr) | {ref_hit, cap_hit};
    end
  end

  assign irq_o = (stat_q[0] && ctrl_q[B_CAP_IE]) || (stat_q[1] && ctrl_q[B_REF_IE]);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      AW'(A_CTRL):  rdata_o = CW'(ctrl_q);
      AW'(A_PRESC): rdata_o = CW'(presc_q);
      AW'(A_REF):   rdata_o = ref_q;
      AW'(A_CAP):   rdata_o = cap_q;
      AW'(A_CNT):   rdata_o = cnt;
      AW'(A_STAT):  rdata_o = CW'(stat_q);
      default:      rdata_o = '0;
    endcase
  end

  assert_cap_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_hit |=> cap_q == $past(cnt) && stat_q[0]);
  assert_ref_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_hit |=> stat_q[1]);
  assert_stat_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stat |=> (stat_q & $past(stat_q)) == $past(stat_q));
  assert_pin_idle_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_en && !wr_ctrl |=> cmp_o);
endmodule

// File: tb/cap_cmp_timer_bench.sv
module cap_cmp_timer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        cap_i = 1'b0;
  logic        evt_i = 1'b0;
  logic        cmp_o, irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  cap_cmp_timer u_cap_cmp_timer (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cap_i, .evt_i, .cmp_o, .irq_o
  );

  localparam int CTRL = 0, PRESC = 1, REF = 2, CAP = 3, CNT = 4, STAT = 5;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = 3'(a); wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] v);
    addr_i = 3'(a);
    #1;
    v = rdata_o;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // stop, clear flags, preload count, then start with ctrl
  task automatic arm(input logic [15:0] ctrl, input logic [15:0] start);
    wr(CTRL, 16'h0);
    wr(STAT, 16'h3);
    wr(CNT, start);
    wr(CTRL, ctrl);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c0;
    waitn(3);
    rst_ni = 1'b1;
    waitn(2);

    // R1
    rd(CNT, v);   chk("R1 cnt", v, 0);
    rd(CAP, v);   chk("R1 cap", v, 0);
    rd(STAT, v);  chk("R1 stat", v, 0);
    rd(PRESC, v); chk("R1 presc", v, 0);
    chk("R1 cmp", cmp_o, 1);
    chk("R1 irq", irq_o, 0);

    // R2 / R12: divider sweep
    wr(REF, 16'hF000);
    wr(CTRL, 16'h0001);
    for (int n = 0; n < 10; n++) begin
      int dv;
      dv = (n < 8) ? n : ((n == 8) ? 15 : 255);
      wr(PRESC, 16'(dv));
      wr(CNT, 16'h0);
      waitn(5 * (dv + 1) + dv);
      rd(CNT, v); chk("R2 before", v, 5);
      waitn(1);
      rd(CNT, v); chk("R2 after", v, 6);
    end
    wr(CTRL, 16'h0);
    wr(CNT, 16'hBEEF);
    rd(CNT, v); chk("R12 load", v, 16'hBEEF);

    // R3: event counting
    wr(PRESC, 16'h0);
    wr(CTRL, 16'h0003);
    wr(CNT, 16'h0);
    waitn(10);
    rd(CNT, v); chk("R3 no clock count", v, 0);
    for (int k = 0; k < 5; k++) begin
      evt_i = 1'b1; waitn(3);
      evt_i = 1'b0; waitn(3);
    end
    waitn(4);
    rd(CNT, v); chk("R3 events", v, 5);

    // R4: wrap
    wr(CTRL, 16'h0001);
    wr(CNT, 16'hFFFE);
    waitn(1); rd(CNT, v); chk("R4 top", v, 16'hFFFF);
    waitn(1); rd(CNT, v); chk("R4 wrap", v, 16'h0000);

    // R5: every edge mode, both polarities
    for (int m = 0; m < 4; m++) begin
      for (int pol = 0; pol < 2; pol++) begin
        logic expf;
        cap_i = (pol == 0) ? 1'b0 : 1'b1;
        wr(CTRL, 16'(1 | (m << 2)));
        waitn(6);
        wr(STAT, 16'h3);
        rd(CNT, c0);
        cap_i = ~cap_i;
        waitn(6);
        expf = (pol == 0) ? m[0] : m[1];
        rd(STAT, v); chk($sformatf("R5 flag m%0d p%0d", m, pol), v[0], expf);
        if (expf) begin
          rd(CAP, v); chk($sformatf("R5 value m%0d p%0d", m, pol), v, c0 + 16'd2);
        end
      end
    end

    // R6 / R8: pulse mode
    wr(REF, 16'h0040);
    arm(16'h0021, 16'h003E);
    waitn(2);
    chk("R8 idle", cmp_o, 1);
    rd(STAT, v); chk("R6 not yet", v[1], 0);
    waitn(1);
    chk("R8 low", cmp_o, 0);
    rd(STAT, v); chk("R6 flag", v[1], 1);
    rd(CNT, v);  chk("R6 next", v, 16'h0041);
    waitn(1);
    chk("R8 release", cmp_o, 1);

    // R7: restart
    arm(16'h0061, 16'h003E);
    waitn(3);
    rd(CNT, v); chk("R7 zero", v, 0);
    waitn(1);
    rd(CNT, v); chk("R7 resume", v, 1);

    // R9: toggle with restart, period 0x41
    arm(16'h0071, 16'h003E);
    waitn(3);
    chk("R9 first flip", cmp_o, 0);
    waitn(64);
    chk("R9 hold", cmp_o, 0);
    waitn(1);
    chk("R9 second flip", cmp_o, 1);
    wr(CTRL, 16'h0071);
    chk("R9 reinit", cmp_o, 1);

    // R13: pin disabled
    arm(16'h0001, 16'h003E);
    waitn(3);
    chk("R13 pin idle", cmp_o, 1);
    rd(STAT, v); chk("R13 flag still set", v[1], 1);

    // capture and compare on the same edge (R5, R6)
    arm(16'h0005, 16'h003E);
    cap_i = 1'b1;
    waitn(3);
    rd(STAT, v); chk("R6 both flags", v, 16'h3);
    rd(CAP, v);  chk("R5 cap at match", v, 16'h0040);
    cap_i = 1'b0;

    // R10: clear racing a set
    arm(16'h0001, 16'h003E);
    waitn(1);
    wr(STAT, 16'h2);
    rd(STAT, v); chk("R10 set wins", v[1], 1);
    wr(STAT, 16'h0);
    rd(STAT, v); chk("R10 write zero keeps", v[1], 1);
    wr(STAT, 16'h3);
    rd(STAT, v); chk("R10 cleared", v, 0);

    // R11
    arm(16'h0101, 16'h003E);
    waitn(3);
    chk("R11 ref irq", irq_o, 1);
    wr(CTRL, 16'h0001);
    chk("R11 masked", irq_o, 0);
    wr(CTRL, 16'h0081);
    chk("R11 wrong enable", irq_o, 0);
    wr(CTRL, 16'h0181);
    chk("R11 reenabled", irq_o, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule